// File: doc/BRIEF.md
# Load-Store Ordering Checker

This block tracks every memory operation in flight inside an out-of-order core. It keeps them in program order in a circular queue. The front end allocates one entry per load, store or fence. Address-resolve events arrive later in any order; each event carries the entry index, the full address and a permission bit. Loads are allowed to run ahead of older stores whose addresses are still unknown.

When a load resolves, the block checks its permission before anything reaches the cache. A permitted load goes out on the issue port. A forbidden load is reported on the fault port, marked blocked, and never sent.

When a store resolves, its address is compared at full width against every younger load that has already executed. The oldest such load is returned to the pending state and reported on the replay port, so the core can squash it and resolve it again.

Entries leave in order through a retire input, which is honoured only when the head entry is finished. A flush input from the reorder buffer discards every entry younger than a given index.

Each entry runs a small state machine with four states:
- FREE: the entry is unused.
- PEND: the entry waits for its address.
- DONE: a store has resolved, a load has issued, or the entry is a fence.
- BLOCK: a load has failed its permission check.

The transitions are:
- alloc: FREE to PEND for a load or store, FREE to DONE for a fence.
- resolve: PEND to DONE for a store or a permitted load, PEND to BLOCK for a forbidden load.
- replay: DONE to PEND for a load.
- kill: any state to FREE, on retire or flush.

Top module: `lsq_order_check`

## Requirements
- R1: After reset the queue is empty: alloc_ready=1, alloc_idx=0, head_ready=0, and issue_valid, fault_valid and replay_valid are 0.
- R2: An accepted allocation takes index alloc_idx, and alloc_idx then advances by one modulo DEPTH. The kind encoding is 0=load, 1=store, 2=fence; code 3 must not be used. With DEPTH entries occupied, alloc_ready=0 and alloc_valid is ignored.
- R3: Resolving a pending load with res_allowed=1 raises issue_valid on the next cycle, with issue_idx and issue_addr equal to the resolved index and address.
- R4: Resolving a pending load with res_allowed=0 raises fault_valid with fault_idx on the next cycle, and issue_valid stays 0. A blocked load never issues, even when it is resolved again.
- R5: Resolving a pending store raises replay_valid on the next cycle if a younger, already-issued load holds an identical address. replay_idx names the oldest such load, counted in circular order from the store. That load returns to pending and issues again when it is re-resolved.
- R6: No replay is reported for loads older than the store, for blocked or still-pending loads, or for addresses that differ in any bit.
- R7: head_ready=1 exactly when the head entry is a resolved store, an issued or blocked load, or a fence. retire_valid frees the head only while head_ready=1 and is ignored otherwise.
- R8: flush_valid with a live flush_idx frees every entry younger than flush_idx, so alloc_idx becomes flush_idx+1. Allocation, retire and resolve presented in the same cycle are ignored, and a later resolve to a freed index has no effect.
- R9: A fence occupies an entry that needs no resolve. It becomes retirable only on reaching the head, that is, after every older operation has left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocate one operation at the tail |
| alloc_kind | input | 2 | Operation kind: 0 load, 1 store, 2 fence |
| alloc_ready | output | 1 | Queue has a free entry |
| alloc_idx | output | $clog2(DEPTH) | Index the next allocation takes |
| res_valid | input | 1 | Address-resolve event |
| res_idx | input | $clog2(DEPTH) | Entry being resolved |
| res_addr | input | AW | Resolved address |
| res_allowed | input | 1 | Permission for a load access |
| issue_valid | output | 1 | Load request sent toward the cache |
| issue_idx | output | $clog2(DEPTH) | Entry of the issued load |
| issue_addr | output | AW | Address of the issued load |
| fault_valid | output | 1 | A load failed its permission check |
| fault_idx | output | $clog2(DEPTH) | Entry of the blocked load |
| replay_valid | output | 1 | A load must be squashed and replayed |
| replay_idx | output | $clog2(DEPTH) | Entry of the load to replay |
| retire_valid | input | 1 | Free the head entry |
| head_ready | output | 1 | Head entry may retire |
| flush_valid | input | 1 | Discard entries younger than flush_idx |
| flush_idx | input | $clog2(DEPTH) | Youngest entry kept by a flush |

## Verification
The bench builds the block with DEPTH=4 and AW=8. At that size four allocations fill the queue, and the tail wraps past index 3 within a short sequence. A replay search can therefore be run across the wrap point, with an older load at a higher index holding the same address as the younger load that must be chosen. Eight-bit addresses keep single-bit mismatches, such as 0x40 against 0x41, easy to set up.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FENCE = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_PEND  = 2'd1,
        SLOT_DONE  = 2'd2,
        SLOT_BLOCK = 2'd3
    } slot_state_e;
endpackage

// File: rtl/lsq_slot.sv
module lsq_slot
    import lsq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  op_kind_e      alloc_kind,
    input  logic          res_en,
    input  logic [AW-1:0] res_addr,
    input  logic          res_ok,
    input  logic          replay_en,
    input  logic          kill_en,
    output slot_state_e   state_o,
    output op_kind_e      kind_o,
    output logic [AW-1:0] addr_o
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (kill_en) begin
            state_d = SLOT_FREE;
        end else begin
            unique case (state_q)
                SLOT_FREE:  if (alloc_en)
                                state_d = (alloc_kind == OP_FENCE) ? SLOT_DONE : SLOT_PEND;
                SLOT_PEND:  if (res_en)
                                state_d = (kind_o == OP_STORE || res_ok) ? SLOT_DONE : SLOT_BLOCK;
                SLOT_DONE:  if (replay_en && kind_o == OP_LOAD)
                                state_d = SLOT_PEND;
                SLOT_BLOCK: state_d = SLOT_BLOCK;
                default:    state_d = SLOT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            kind_o  <= OP_LOAD;
            addr_o  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_FREE && alloc_en) kind_o <= alloc_kind;
            if (state_q == SLOT_PEND && res_en)   addr_o <= res_addr;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/lsq_conflict.sv
module lsq_conflict #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic [IW-1:0]           base_idx,
    input  logic [CW-1:0]           span,
    input  logic [AW-1:0]           addr,
    input  logic [DEPTH-1:0]        exec_load,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    output logic                    hit,
    output logic [IW-1:0]           hit_idx
);
    logic [IW-1:0] probe;

    // walk forward from the store; first match is the oldest younger load
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        probe   = '0;
        for (int k = 1; k < DEPTH; k++) begin
            probe = base_idx + IW'(k);
            if (!hit && CW'(k) <= span && exec_load[probe] && slot_addr[probe] == addr) begin
                hit     = 1'b1;
                hit_idx = probe;
            end
        end
    end
endmodule

// File: rtl/lsq_order_check.sv
module lsq_order_check
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [1:0]    alloc_kind,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    input  logic          res_valid,
    input  logic [IW-1:0] res_idx,
    input  logic [AW-1:0] res_addr,
    input  logic          res_allowed,
    output logic          issue_valid,
    output logic [IW-1:0] issue_idx,
    output logic [AW-1:0] issue_addr,
    output logic          fault_valid,
    output logic [IW-1:0] fault_idx,
    output logic          replay_valid,
    output logic [IW-1:0] replay_idx,
    input  logic          retire_valid,
    output logic          head_ready,
    input  logic          flush_valid,
    input  logic [IW-1:0] flush_idx
);
    logic [IW-1:0] head_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] res_age, flush_age;
    logic          res_live, flush_live;
    logic          alloc_go, retire_go, res_go, flush_go;
    logic          load_res, store_res;
    logic          cf_hit;
    logic [IW-1:0] cf_idx;
    logic [CW-1:0] cf_span;

    slot_state_e            st [DEPTH];
    op_kind_e               kd [DEPTH];
    logic [DEPTH-1:0][AW-1:0] ad;
    logic [DEPTH-1:0]       exec_load;

    assign alloc_idx   = head_q + cnt_q[IW-1:0];
    assign alloc_ready = (cnt_q != CW'(DEPTH));
    assign head_ready  = (cnt_q != '0) &&
                         (st[head_q] == SLOT_DONE || st[head_q] == SLOT_BLOCK);

    assign res_age    = res_idx - head_q;
    assign flush_age  = flush_idx - head_q;
    assign res_live   = {1'b0, res_age} < cnt_q;
    assign flush_live = {1'b0, flush_age} < cnt_q;

    assign flush_go  = flush_valid && flush_live;
    assign alloc_go  = alloc_valid && alloc_ready && !flush_valid;
    assign retire_go = retire_valid && head_ready && !flush_valid;
    assign res_go    = res_valid && res_live && !flush_valid;

    assign load_res  = res_go && kd[res_idx] == OP_LOAD  && st[res_idx] == SLOT_PEND;
    assign store_res = res_go && kd[res_idx] == OP_STORE && st[res_idx] == SLOT_PEND;
    assign cf_span   = cnt_q - CW'(1) - {1'b0, res_age};

    lsq_conflict #(.DEPTH(DEPTH), .AW(AW)) u_conflict (
        .base_idx  (res_idx),
        .span      (cf_span),
        .addr      (res_addr),
        .exec_load (exec_load),
        .slot_addr (ad),
        .hit       (cf_hit),
        .hit_idx   (cf_idx)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [IW-1:0] sage;
        logic          kill;
        assign sage = IW'(g) - head_q;
        assign kill = (retire_go && head_q == IW'(g)) || (flush_go && sage > flush_age);
        assign exec_load[g] = (st[g] == SLOT_DONE) && (kd[g] == OP_LOAD);

        lsq_slot #(.AW(AW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_go && alloc_idx == IW'(g)),
            .alloc_kind (op_kind_e'(alloc_kind)),
            .res_en     (res_go && res_idx == IW'(g)),
            .res_addr   (res_addr),
            .res_ok     (res_allowed),
            .replay_en  (store_res && cf_hit && cf_idx == IW'(g)),
            .kill_en    (kill),
            .state_o    (st[g]),
            .kind_o     (kd[g]),
            .addr_o     (ad[g])
        );
    end

    // queue occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else if (flush_go) begin
            cnt_q <= {1'b0, flush_age} + CW'(1);
        end else begin
            head_q <= head_q + IW'(retire_go);
            cnt_q  <= cnt_q + CW'(alloc_go) - CW'(retire_go);
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_valid  <= 1'b0;
            issue_idx    <= '0;
            issue_addr   <= '0;
            fault_valid  <= 1'b0;
            fault_idx    <= '0;
            replay_valid <= 1'b0;
            replay_idx   <= '0;
        end else begin
            issue_valid  <= load_res && res_allowed;
            issue_idx    <= res_idx;
            issue_addr   <= res_addr;
            fault_valid  <= load_res && !res_allowed;
            fault_idx    <= res_idx;
            replay_valid <= store_res && cf_hit;
            replay_idx   <= cf_idx;
        end
    end
endmodule

// File: rtl/lsq_order_check_chk.sv
module lsq_order_check_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          res_valid,
    input logic          res_allowed,
    input logic          issue_valid,
    input logic          fault_valid,
    input logic          replay_valid,
    input logic [CW-1:0] cnt
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_issue_permitted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> $past(res_valid && res_allowed));

    assert_fault_forbidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(res_valid && !res_allowed));

    assert_issue_fault_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && fault_valid));

    assert_replay_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> $past(res_valid && !res_allowed || res_valid));
endmodule

bind lsq_order_check lsq_order_check_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid    (res_valid),
    .res_allowed  (res_allowed),
    .issue_valid  (issue_valid),
    .fault_valid  (fault_valid),
    .replay_valid (replay_valid),
    .cnt          (cnt_q)
);

// File: tb/test_lsq_order_check.sv
module test_lsq_order_check;
    localparam int DEPTH = 4;
    localparam int AW    = 8;

    typedef struct packed {
        logic [2:0] op;     // 0 nop, 1 alloc, 2 resolve, 3 retire, 4 flush
        logic [1:0] arg;    // kind or index
        logic [7:0] addr;
        logic       ok;
        logic       e_iss;
        logic       e_flt;
        logic       e_rep;
        logic [1:0] e_ridx;
        logic [1:0] e_aidx;
        logic       e_hr;
        logic [3:0] req;
    } vec_t;

    // op, arg, addr, ok, iss, flt, rep, ridx, aidx, hr, req
    localparam vec_t VEC [20] = '{
        '{3'd1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 4'd2}, // R2 store
        '{3'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 4'd2}, // R2 load
        '{3'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd2},
        '{3'd2, 2'd2, 8'h40, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd3}, // R3
        '{3'd2, 2'd1, 8'h40, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 4'd3},
        '{3'd2, 2'd0, 8'h40, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd3, 1'b1, 4'd5}, // R5 oldest
        '{3'd2, 2'd1, 8'h40, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1, 4'd5}, // R5 reissue
        '{3'd3, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1, 4'd7}, // R7
        '{3'd1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd9}, // R9 fence
        '{3'd3, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd7},
        '{3'd3, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd9}, // R9 fence head
        '{3'd3, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd7},
        '{3'd1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 4'd2},
        '{3'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 4'd2},
        '{3'd2, 2'd1, 8'h41, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 4'd3},
        '{3'd2, 2'd0, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1, 4'd6}, // R6 one bit off
        '{3'd1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1, 4'd2},
        '{3'd1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd2},
        '{3'd2, 2'd3, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1, 4'd4}, // R4
        '{3'd2, 2'd2, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd6}  // R6 blocked
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [1:0]    alloc_kind = '0;
    logic          alloc_ready;
    logic [1:0]    alloc_idx;
    logic          res_valid = 1'b0;
    logic [1:0]    res_idx = '0;
    logic [AW-1:0] res_addr = '0;
    logic          res_allowed = 1'b0;
    logic          issue_valid;
    logic [1:0]    issue_idx;
    logic [AW-1:0] issue_addr;
    logic          fault_valid;
    logic [1:0]    fault_idx;
    logic          replay_valid;
    logic [1:0]    replay_idx;
    logic          retire_valid = 1'b0;
    logic          head_ready;
    logic          flush_valid = 1'b0;
    logic [1:0]    flush_idx = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsq_order_check #(.DEPTH(DEPTH), .AW(AW)) i_lsq_order_check (
        .clk, .rst_n, .alloc_valid, .alloc_kind, .alloc_ready, .alloc_idx,
        .res_valid, .res_idx, .res_addr, .res_allowed,
        .issue_valid, .issue_idx, .issue_addr, .fault_valid, .fault_idx,
        .replay_valid, .replay_idx, .retire_valid, .head_ready,
        .flush_valid, .flush_idx
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [1:0] arg,
                         input logic [7:0] addr, input logic ok);
        case (op)
            3'd1: begin alloc_valid = 1'b1; alloc_kind = arg; end
            3'd2: begin res_valid = 1'b1; res_idx = arg; res_addr = addr; res_allowed = ok; end
            3'd3: retire_valid = 1'b1;
            3'd4: begin flush_valid = 1'b1; flush_idx = arg; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0; res_valid = 1'b0; retire_valid = 1'b0; flush_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 alloc_ready", alloc_ready, 1);
        check("R1 alloc_idx", alloc_idx, 0);
        check("R1 head_ready", head_ready, 0);
        check("R1 pulses", {issue_valid, fault_valid, replay_valid}, 0);

        for (int i = 0; i < 20; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VEC[i].req, i);
            do_op(VEC[i].op, VEC[i].arg, VEC[i].addr, VEC[i].ok);
            check({t, " issue_valid"}, issue_valid, VEC[i].e_iss);
            if (VEC[i].e_iss) begin
                check({t, " issue_idx"}, issue_idx, VEC[i].arg);
                check({t, " issue_addr"}, issue_addr, VEC[i].addr);
            end
            check({t, " fault_valid"}, fault_valid, VEC[i].e_flt);
            if (VEC[i].e_flt) check({t, " fault_idx"}, fault_idx, VEC[i].arg);
            check({t, " replay_valid"}, replay_valid, VEC[i].e_rep);
            if (VEC[i].e_rep) check({t, " replay_idx"}, replay_idx, VEC[i].e_ridx);
            check({t, " alloc_idx"}, alloc_idx, VEC[i].e_aidx);
            check({t, " head_ready"}, head_ready, VEC[i].e_hr);
        end

        // R2 full queue refuses allocation
        check("R2 full alloc_ready", alloc_ready, 0);
        do_op(3'd1, 2'd0, 8'h00, 1'b0);
        check("R2 alloc ignored idx", alloc_idx, 0);
        check("R2 alloc ignored ready", alloc_ready, 0);
        // R4 blocked load never issues
        do_op(3'd2, 2'd3, 8'h80, 1'b1);
        check("R4 blocked reresolve", issue_valid, 0);

        // R8 flush keeps entries 0 and 1
        do_op(3'd4, 2'd1, 8'h00, 1'b0);
        check("R8 flush alloc_idx", alloc_idx, 2);
        check("R8 flush alloc_ready", alloc_ready, 1);
        do_op(3'd2, 2'd3, 8'h22, 1'b1);
        check("R8 freed resolve ignored", issue_valid, 0);
        // R8 same-cycle allocation ignored during a flush
        alloc_valid = 1'b1; alloc_kind = 2'd0;
        do_op(3'd4, 2'd1, 8'h00, 1'b0);
        check("R8 alloc during flush", alloc_idx, 2);

        // R7 retire gating
        do_op(3'd1, 2'd0, 8'h00, 1'b0);
        do_op(3'd3, 2'd0, 8'h00, 1'b0);
        check("R7 head load ready", head_ready, 1);
        do_op(3'd3, 2'd0, 8'h00, 1'b0);
        check("R7 pending head", head_ready, 0);
        do_op(3'd3, 2'd0, 8'h00, 1'b0);
        check("R7 retire ignored idx", alloc_idx, 3);
        do_op(3'd2, 2'd2, 8'h10, 1'b1);
        check("R7 entry kept issue", issue_valid, 1);
        check("R7 entry kept idx", issue_idx, 2);
        check("R7 head now ready", head_ready, 1);

        // R5 R6 wrap: older load at idx2 same address, younger at idx0
        do_op(3'd1, 2'd1, 8'h00, 1'b0);
        do_op(3'd1, 2'd0, 8'h00, 1'b0);
        check("R2 wrap alloc_idx", alloc_idx, 1);
        do_op(3'd2, 2'd0, 8'h10, 1'b1);
        check("R3 wrap issue", issue_valid, 1);
        do_op(3'd2, 2'd3, 8'h10, 1'b0);
        check("R5 wrap replay", replay_valid, 1);
        check("R6 older ignored idx", replay_idx, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule